// File: doc/BRIEF.md
# Subtractive GCD Core

This block finds the greatest common divisor of two unsigned operands by repeated subtraction. A controller state machine drives a small register datapath: two working registers (A and B), one subtractor per register, a two-way source select in front of each register, and a comparator. A third register holds the finished result. While the start pin is low the controller keeps circling between a wait state and a join state.

Once start is seen high, the core captures the A operand in the next cycle and the B operand in the cycle after that. It then loops. On each pass it tests whether A and B differ and, if they do, takes the smaller value away from the larger. When the two values match, the common value moves into the result register. The result register and a single-cycle strobe update on the same clock edge. If either operand is zero, the loop is skipped and the other operand is reported, so the core always ends.

Start and the operands are plain control and data pins with no handshake. The core gives no back-pressure of its own. The caller must hold both operands steady from the cycle it raises start until the B operand has been captured. A start level that is still high when a result completes launches the next computation. The result pins keep their value until the next result replaces it.

Top module: `gcd_subtract_core`

## Requirements
- R1: While the synchronous active-high reset is applied, the controller returns to its idle state, the result is cleared to zero and the strobe is low.
- R2: While start is low, the core loads nothing. The result keeps its value, no strobe is produced, and operand changes have no effect.
- R3: When start is seen high in the wait state, A is loaded from opa_in in the next cycle and B from opb_in in the cycle after that. Later operand changes do not affect the computation.
- R4: Each iteration changes exactly one working register. If A is below B, B becomes B minus A; otherwise A becomes A minus B. No subtraction ever wraps.
- R5: When A equals B, the result register takes that common value. For example, operands 42 and 8 give 2, and every pair gives its greatest common divisor.
- R6: result_strobe is high for exactly one cycle, in the same cycle the new result first appears. At all other times the result holds its value.
- R7: If exactly one operand is zero, the result is the other operand. If both are zero, the result is 0. In either case no iteration runs.
- R8: The controller steps through 13 states with 4-bit codes 0 to 12, in this order: idle, wait, start-join, load-A, load-B, differ-test, order-test, reduce-B, reduce-A, branch-join, loop-join, output, return-join. The resulting latencies from the first cycle after reset with start high are: the strobe follows 6 edges later for equal operands, and 11 edges later for a pair that needs one subtraction. A start held high produces strobes 7 cycles apart for equal operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches a computation when seen high in the wait state |
| opa_in | input | WIDTH | First operand, captured one cycle after start is seen |
| opb_in | input | WIDTH | Second operand, captured two cycles after start is seen |
| result | output | WIDTH | Greatest common divisor of the last completed computation |
| result_strobe | output | 1 | One-cycle pulse marking a new value on result |

## Verification
The assertions assume three things about the inputs. Reset is high from time zero. Start is sampled only at clock edges. The operands do not move between start and the capture of B. Without that last condition the "no wrap" and zero-guard properties could still hold while the reported value is meaningless. The bench drives every input at the falling clock edge. It keeps each operand pair fixed until the strobe returns, except in the one capture test, which changes the operands only after B has been loaded. Latency checks start from a reset release with start already high, so the position of the state machine in its wait loop is known exactly.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_WAIT     = 4'd1,
    ST_GOJOIN   = 4'd2,
    ST_LOADA    = 4'd3,
    ST_LOADB    = 4'd4,
    ST_NEQ      = 4'd5,
    ST_LT       = 4'd6,
    ST_SUBB     = 4'd7,
    ST_SUBA     = 4'd8,
    ST_IFJOIN   = 4'd9,
    ST_LOOPJOIN = 4'd10,
    ST_OUTPUT   = 4'd11,
    ST_OUTJOIN  = 4'd12
  } gcd_state_e;

  localparam logic PICK_EXT  = 1'b0;
  localparam logic PICK_DIFF = 1'b1;

  typedef struct packed {
    logic a_pick;
    logic a_load;
    logic b_pick;
    logic b_load;
    logic res_load;
  } dp_ctrl_t;

  typedef struct packed {
    logic differ;
    logic a_below;
    logic any_zero;
  } dp_stat_t;

endpackage

// File: rtl/gcd_lane.sv
module gcd_lane #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ext_val,
  input  logic [W-1:0] peer_val,
  input  logic         pick,
  input  logic         load,
  output logic [W-1:0] val
);
  import gcd_pkg::*;

  logic [W-1:0] diff;

  assign diff = val - peer_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      val <= '0;
    end else if (load) begin
      val <= (pick == PICK_DIFF) ? diff : ext_val;
    end
  end

  // R4: a register that is not loaded keeps its value
  assert_lane_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(val));

endmodule

// File: rtl/gcd_compare.sv
module gcd_compare #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]     a_val,
  input  logic [W-1:0]     b_val,
  output gcd_pkg::dp_stat_t stat
);
  always_comb begin
    stat.differ   = (a_val != b_val);
    stat.a_below  = (a_val < b_val);
    stat.any_zero = (a_val == '0) || (b_val == '0);
  end

endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath #(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      opa_in,
  input  logic [W-1:0]      opb_in,
  input  gcd_pkg::dp_ctrl_t ctl,
  output gcd_pkg::dp_stat_t stat,
  output logic [W-1:0]      result
);
  import gcd_pkg::*;

  localparam int unsigned LANES = 2;

  logic [W-1:0] ext_v  [LANES];
  logic [W-1:0] cur_v  [LANES];
  logic [LANES-1:0] pick_v;
  logic [LANES-1:0] load_v;
  logic [W-1:0] res_src;

  assign ext_v[0]  = opa_in;
  assign ext_v[1]  = opb_in;
  assign pick_v    = {ctl.b_pick, ctl.a_pick};
  assign load_v    = {ctl.b_load, ctl.a_load};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    gcd_lane #(.W(W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .ext_val  (ext_v[g]),
      .peer_val (cur_v[LANES-1-g]),
      .pick     (pick_v[g]),
      .load     (load_v[g]),
      .val      (cur_v[g])
    );
  end

  gcd_compare #(.W(W)) u_cmp (
    .a_val (cur_v[0]),
    .b_val (cur_v[1]),
    .stat  (stat)
  );

  // zero guard: a zero A reports B (also covers both zero)
  assign res_src = (cur_v[0] == '0) ? cur_v[1] : cur_v[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else if (ctl.res_load) begin
      result <= res_src;
    end
  end

  assert_reduce_a_order_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl.a_load && ctl.a_pick == PICK_DIFF) |-> (cur_v[1] <= cur_v[0]));

  assert_reduce_b_order_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl.b_load && ctl.b_pick == PICK_DIFF) |-> (cur_v[0] < cur_v[1]));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    !(ctl.a_load && ctl.b_load));

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !ctl.res_load |=> $stable(result));

  assert_zero_guard_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl.res_load && cur_v[0] == '0) |=> (result == $past(cur_v[1])));

endmodule

// File: rtl/gcd_fsm.sv
module gcd_fsm (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  gcd_pkg::dp_stat_t stat,
  output gcd_pkg::dp_ctrl_t ctl,
  output logic              strobe
);
  import gcd_pkg::*;

  gcd_state_e state, nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      strobe <= 1'b0;
    end else begin
      state  <= nxt;
      strobe <= (state == ST_OUTPUT);
    end
  end

  always_comb begin
    nxt = ST_IDLE;
    unique case (state)
      ST_IDLE:     nxt = ST_WAIT;
      ST_WAIT:     nxt = start ? ST_LOADA : ST_GOJOIN;
      ST_GOJOIN:   nxt = ST_WAIT;
      ST_LOADA:    nxt = ST_LOADB;
      ST_LOADB:    nxt = ST_NEQ;
      ST_NEQ:      nxt = (stat.differ && !stat.any_zero) ? ST_LT : ST_OUTPUT;
      ST_LT:       nxt = stat.a_below ? ST_SUBB : ST_SUBA;
      ST_SUBB:     nxt = ST_IFJOIN;
      ST_SUBA:     nxt = ST_IFJOIN;
      ST_IFJOIN:   nxt = ST_LOOPJOIN;
      ST_LOOPJOIN: nxt = ST_NEQ;
      ST_OUTPUT:   nxt = ST_OUTJOIN;
      ST_OUTJOIN:  nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl = '0;
    unique case (state)
      ST_LOADA: begin ctl.a_pick = PICK_EXT;  ctl.a_load = 1'b1; end
      ST_LOADB: begin ctl.b_pick = PICK_EXT;  ctl.b_load = 1'b1; end
      ST_SUBB:  begin ctl.b_pick = PICK_DIFF; ctl.b_load = 1'b1; end
      ST_SUBA:  begin ctl.a_pick = PICK_DIFF; ctl.a_load = 1'b1; end
      ST_OUTPUT: ctl.res_load = 1'b1;
      default: ctl = '0;
    endcase
  end

  assert_state_legal_R8: assert property (@(posedge clk) disable iff (rst)
    state inside {[ST_IDLE:ST_OUTJOIN]});

  assert_idle_to_wait_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |=> (state == ST_WAIT));

  assert_wait_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !start) |=> (state == ST_GOJOIN));

  assert_loop_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_NEQ && !stat.differ) |=> (state == ST_OUTPUT));

  assert_strobe_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);

endmodule

// File: rtl/gcd_subtract_core.sv
module gcd_subtract_core #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] opa_in,
  input  logic [WIDTH-1:0] opb_in,
  output logic [WIDTH-1:0] result,
  output logic             result_strobe
);
  import gcd_pkg::*;

  dp_ctrl_t ctl;
  dp_stat_t stat;

  gcd_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .stat   (stat),
    .ctl    (ctl),
    .strobe (result_strobe)
  );

  gcd_datapath #(.W(WIDTH)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .opa_in (opa_in),
    .opb_in (opb_in),
    .ctl    (ctl),
    .stat   (stat),
    .result (result)
  );

  // R6: the strobe follows the result load by one edge
  assert_strobe_after_load_R6: assert property (@(posedge clk) disable iff (rst)
    ctl.res_load |=> result_strobe);

endmodule

// File: tb/test_gcd_subtract_core.sv
`timescale 1ns/1ps
module test_gcd_subtract_core;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] opa_in = '0;
  logic [W-1:0] opb_in = '0;
  logic [W-1:0] result;
  logic result_strobe;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  gcd_subtract_core #(.WIDTH(W)) i_gcd_subtract_core (
    .clk(clk), .rst(rst), .start(start), .opa_in(opa_in), .opb_in(opb_in),
    .result(result), .result_strobe(result_strobe)
  );

  function automatic int ref_gcd(input int a, input int b);
    int x = a;
    int y = b;
    while (y != 0) begin
      int t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic reset_dut(input logic st, input int a, input int b);
    @(negedge clk);
    rst = 1'b1; start = st; opa_in = W'(a); opb_in = W'(b);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_strobe(output int cyc);
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (result_strobe) break;
      if (cyc > 4000) begin
        check(1'b0, "R5 strobe timeout", cyc, 0);
        break;
      end
    end
  endtask

  task automatic run_op(input int a, input int b, input string req);
    int cyc;
    @(negedge clk);
    opa_in = W'(a); opb_in = W'(b); start = 1'b1;
    wait_strobe(cyc);
    start = 1'b0;
    check(int'(result) == ref_gcd(a, b), req, int'(result), ref_gcd(a, b));
  endtask

  task automatic t_reset;
    reset_dut(1'b0, 5, 7);
    check(result == '0, "R1 result after reset", int'(result), 0);
    check(result_strobe == 1'b0, "R1 strobe after reset", int'(result_strobe), 0);
  endtask

  task automatic t_idle;
    int seen = 0;
    for (int i = 0; i < 40; i++) begin
      opa_in = W'(i * 7 + 3); opb_in = W'(i * 5 + 1);
      @(negedge clk);
      if (result_strobe) seen++;
    end
    check(seen == 0, "R2 no strobe while start low", seen, 0);
    check(result == '0, "R2 result unchanged while idle", int'(result), 0);
  endtask

  task automatic t_latency;
    int cyc;
    reset_dut(1'b1, 9, 9);
    wait_strobe(cyc);
    check(cyc == 6, "R8 latency equal operands", cyc, 6);
    check(result == 8'd9, "R5 equal operands", int'(result), 9);
    wait_strobe(cyc);
    check(cyc == 7, "R8 back-to-back spacing", cyc, 7);
    start = 1'b0;
    reset_dut(1'b1, 6, 3);
    wait_strobe(cyc);
    check(cyc == 11, "R8 latency one reduce-A step", cyc, 11);
    check(result == 8'd3, "R4 reduce-A result", int'(result), 3);
    start = 1'b0;
    reset_dut(1'b1, 3, 6);
    wait_strobe(cyc);
    check(cyc == 11, "R8 latency one reduce-B step", cyc, 11);
    check(result == 8'd3, "R4 reduce-B result", int'(result), 3);
    start = 1'b0;
  endtask

  task automatic t_capture;
    int cyc;
    reset_dut(1'b1, 42, 8);
    repeat (4) @(negedge clk);
    opa_in = 8'd200; opb_in = 8'd100; start = 1'b0;
    wait_strobe(cyc);
    check(result == 8'd2, "R3 R5 capture 42,8 gives 2", int'(result), 2);
  endtask

  task automatic t_known;
    run_op(255, 1, "R5 255,1");
    run_op(1, 255, "R5 1,255");
    run_op(100, 75, "R5 100,75");
    run_op(17, 13, "R5 17,13");
    run_op(128, 64, "R4 128,64");
    run_op(255, 255, "R5 255,255");
    run_op(200, 150, "R4 200,150");
    run_op(91, 49, "R5 91,49");
  endtask

  task automatic t_zero;
    int cyc;
    reset_dut(1'b1, 0, 37);
    wait_strobe(cyc);
    check(cyc == 6, "R7 zero operand skips loop", cyc, 6);
    check(result == 8'd37, "R7 0,37", int'(result), 37);
    start = 1'b0;
    run_op(37, 0, "R7 37,0");
    run_op(0, 0, "R7 0,0");
  endtask

  task automatic t_strobe;
    int seen = 0;
    logic [W-1:0] held;
    run_op(84, 36, "R5 84,36");
    held = result;
    @(negedge clk);
    check(result_strobe == 1'b0, "R6 strobe one cycle", int'(result_strobe), 0);
    for (int i = 0; i < 30; i++) begin
      opa_in = W'(i + 11); opb_in = W'(i + 2);
      @(negedge clk);
      if (result_strobe) seen++;
      if (result != held) seen++;
    end
    check(seen == 0, "R6 result held, no extra strobe", seen, 0);
    check(result == held, "R6 held value", int'(result), int'(held));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog R5 actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_latency();
    t_capture();
    t_known();
    t_zero();
    t_strobe();
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule